// File: doc/BRIEF.md
# Video Controller Command Port Latch

This block sits behind the host control and data ports of a tile-based video display controller. A host writes 16-bit words to the control port. Two words in a row form a command: a 16-bit video memory address and a 6-bit access code. A single word whose top two bits are `10` is a register write instead. The block keeps the three register fields it needs itself, and it passes every register write on to the rest of the controller.

Data-port writes enter a small write queue. Each entry is stamped with the cycle at which it may leave. The stamp depends on whether the display runs in wide (40-cell) or narrow (32-cell) mode. The block decides when a DMA transfer begins. Copy and host-to-memory transfers begin as soon as the second command word arrives. A fill transfer only arms on the command and begins when the queued fill word has drained from the queue. The block also assembles the status bits for busy, blanking and region.

Top module: `cmdport_latch`

## Requirements
- R1: When no command is pending, a control write whose bits 15:14 are not `10` loads address bits 13:0 from data bits 13:0 and access code bits 1:0 from data bits 15:14. It keeps address bits 15:14 and sets the pending flag.
- R2: When a command is pending, a control write replaces address bits 15:14 with data bits 1:0. It clears the pending flag and pulses `rd_flush` for that cycle.
- R3: On the second word, access code bits 4:2 take data bits 6:4 and bit 5 takes data bit 7. Bits 1:0 keep the value loaded by the first word.
- R4: When the DMA-enable bit (register 1, bit 4) is clear, the second word leaves access code bit 5 unchanged.
- R5: If the second word leaves code bit 5 set and the transfer-kind field (register 23, bits 7:6) is not `10`, `dma_run` rises on that clock edge and `dma_code` latches the new access code.
- R6: If the kind field is `10` (fill), the second word does not start DMA. `dma_run` rises one cycle after the queue's last entry leaves while code bit 5 is set. An entry that drains while bit 5 is clear starts nothing.
- R7: While `dma_run` is high, every control write is ignored: address, access code and pending flag are unchanged and no register write is issued.
- R8: A first word with bits 15:14 equal to `10` issues a register write with index = data bits 12:8 and value = data bits 7:0. It clears access code bits 1:0 and leaves the address and the pending flag unchanged.
- R9: `status[1]` equals access code bit 5 and `status[0]` equals `pal_region`. `status[2]` is set when `hslot` is below the blanking-end slot or above the blanking-start slot. The slots are 11/166 in wide mode and 10/133 in narrow mode. Register 12, bit 0 selects wide mode.
- R10: A data write leaves the queue (pulse on `wr_valid` with its address, data and access code) exactly 16×LAT cycles after the write in wide mode, or 20×LAT cycles in narrow mode (LAT = 3 by default).
- R11: `dma_done` clears `dma_run` and access code bit 5 on the next edge.
- R12: A data write that arrives while the queue holds DEPTH entries (4 by default) is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control port write strobe |
| ctl_wdata | input | 16 | Control port write word |
| dat_we | input | 1 | Data port write strobe |
| dat_wdata | input | 16 | Data port write word |
| hslot | input | 9 | Current horizontal slot |
| pal_region | input | 1 | Region strap, 1 = 50 Hz region |
| dma_done | input | 1 | DMA engine finished |
| cmd_addr | output | 16 | Assembled memory address |
| cmd_code | output | 6 | Assembled access code |
| cmd_pending | output | 1 | First command word held |
| rd_flush | output | 1 | Drop any read prefetch |
| reg_we | output | 1 | Register write strobe |
| reg_idx | output | 5 | Register index |
| reg_val | output | 8 | Register value |
| dma_run | output | 1 | DMA transfer running |
| dma_code | output | 6 | Access code latched at DMA start |
| wr_valid | output | 1 | Queue entry leaving |
| wr_addr | output | 16 | Leaving entry address |
| wr_data | output | 16 | Leaving entry data |
| wr_code | output | 6 | Leaving entry access code |
| status | output | 3 | {blanking, busy, region} |

## Verification
A wrong pending flag shows up on the very next control word: that word lands in the wrong half of the address and the code, so `cmd_addr` and `cmd_code` are wrong one cycle later. A bad keep mask or a bad start decision shows on `status[1]` and `dma_run` at the edge of the second word. For fill, `dma_run` rises either too early, at the command, or one cycle away from the moment the queue empties. Stamp or pointer errors show as a `wr_valid` pulse at the wrong cycle count after a data write, or as the wrong number of pulses after a burst into a full queue.

// File: rtl/cmdport_latch.sv
module cmdport_latch #(
  parameter int DEPTH        = 4,
  parameter int LAT          = 3,
  parameter int TW           = 16,
  parameter int HB_END_WIDE  = 11,
  parameter int HB_BEG_WIDE  = 166,
  parameter int HB_END_NARR  = 10,
  parameter int HB_BEG_NARR  = 133
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_we,
  input  logic [15:0] ctl_wdata,
  input  logic        dat_we,
  input  logic [15:0] dat_wdata,
  input  logic [8:0]  hslot,
  input  logic        pal_region,
  input  logic        dma_done,
  output logic [15:0] cmd_addr,
  output logic [5:0]  cmd_code,
  output logic        cmd_pending,
  output logic        rd_flush,
  output logic        reg_we,
  output logic [4:0]  reg_idx,
  output logic [7:0]  reg_val,
  output logic        dma_run,
  output logic [5:0]  dma_code,
  output logic        wr_valid,
  output logic [15:0] wr_addr,
  output logic [15:0] wr_data,
  output logic [5:0]  wr_code,
  output logic [2:0]  status
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0]   DEPTH_C  = (AW+1)'(DEPTH);
  localparam logic [TW-1:0] WAIT_W   = TW'(16 * LAT);
  localparam logic [TW-1:0] WAIT_N   = TW'(20 * LAT);
  localparam logic [4:0]    IDX_MODE = 5'd1;
  localparam logic [4:0]    IDX_GEOM = 5'd12;
  localparam logic [4:0]    IDX_KIND = 5'd23;

  logic        dma_en, wide;
  logic [1:0]  kind;
  logic [5:0]  code_n, code_sec, keep;
  logic        run_n;
  logic [5:0]  dcode_n;
  logic        ok, second, first, regw, fill;

  logic [15:0]   q_addr  [DEPTH];
  logic [15:0]   q_data  [DEPTH];
  logic [5:0]    q_code  [DEPTH];
  logic [TW-1:0] q_stamp [DEPTH];
  logic [AW:0]   wp, rp, cnt;
  logic [TW-1:0] now, age;
  logic          push, pop, empty, full, drained;

  assign ok     = ctl_we && !dma_run;
  assign second = ok && cmd_pending;
  assign first  = ok && !cmd_pending && ctl_wdata[15:14] != 2'b10;
  assign regw   = ok && !cmd_pending && ctl_wdata[15:14] == 2'b10;
  assign fill   = kind == 2'b10;
  assign keep   = dma_en ? 6'h03 : 6'h23;
  assign code_sec = (cmd_code & keep) | ({ctl_wdata[7:4], 2'b00} & ~keep);

  assign rd_flush = second;
  assign reg_we   = regw;
  assign reg_idx  = ctl_wdata[12:8];
  assign reg_val  = ctl_wdata[7:0];

  assign cnt     = wp - rp;
  assign empty   = cnt == '0;
  assign full    = cnt == DEPTH_C;
  assign push    = dat_we && !full;
  assign age     = now - q_stamp[rp[AW-1:0]];
  assign pop     = !empty && !age[TW-1];
  assign drained = pop && cnt == (AW+1)'(1) && !push;

  assign wr_valid = pop;
  assign wr_addr  = q_addr[rp[AW-1:0]];
  assign wr_data  = q_data[rp[AW-1:0]];
  assign wr_code  = q_code[rp[AW-1:0]];

  always_comb begin
    code_n  = cmd_code;
    run_n   = dma_run;
    dcode_n = dma_code;
    if (second) begin
      code_n = code_sec;
      if (code_sec[5] && !fill) begin
        run_n   = 1'b1;
        dcode_n = code_sec;
      end
    end else if (first) begin
      code_n[1:0] = ctl_wdata[15:14];
    end else if (regw) begin
      code_n = cmd_code & 6'h3C;
    end
    if (drained && cmd_code[5] && fill) begin
      run_n   = 1'b1;
      dcode_n = cmd_code;
    end
    if (dma_done) begin
      run_n     = 1'b0;
      code_n[5] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_addr    <= '0;
      cmd_code    <= '0;
      cmd_pending <= 1'b0;
      dma_run     <= 1'b0;
      dma_code    <= '0;
      dma_en      <= 1'b0;
      wide        <= 1'b0;
      kind        <= 2'b00;
    end else begin
      cmd_code <= code_n;
      dma_run  <= run_n;
      dma_code <= dcode_n;
      if (second) begin
        cmd_addr[15:14] <= ctl_wdata[1:0];
        cmd_pending     <= 1'b0;
      end else if (first) begin
        cmd_addr[13:0] <= ctl_wdata[13:0];
        cmd_pending    <= 1'b1;
      end
      if (regw) begin
        if (reg_idx == IDX_MODE) dma_en <= reg_val[4];
        if (reg_idx == IDX_GEOM) wide   <= reg_val[0];
        if (reg_idx == IDX_KIND) kind   <= reg_val[7:6];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      now <= '0;
    end else begin
      now <= now + 1'b1;
      if (push) begin
        q_addr[wp[AW-1:0]]  <= cmd_addr;
        q_data[wp[AW-1:0]]  <= dat_wdata;
        q_code[wp[AW-1:0]]  <= cmd_code;
        q_stamp[wp[AW-1:0]] <= now + (wide ? WAIT_W : WAIT_N);
        wp <= wp + 1'b1;
      end
      if (pop) rp <= rp + 1'b1;
    end
  end

  logic blank;
  assign blank = wide ? (int'(hslot) < HB_END_WIDE || int'(hslot) > HB_BEG_WIDE)
                      : (int'(hslot) < HB_END_NARR || int'(hslot) > HB_BEG_NARR);
  assign status = {blank, cmd_code[5], pal_region};

  AST_REJECT_WHILE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    dma_run && ctl_we && !dma_done |=> $stable(cmd_addr) && $stable(cmd_code) && $stable(cmd_pending)); // R7
  AST_SECOND_CLEARS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we && !dma_run && cmd_pending |=> !cmd_pending); // R2
  AST_FILL_DEFERRED: assert property (@(posedge clk) disable iff (!rst_n)
    second && fill && !pop && !dma_run |=> !dma_run); // R6
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    dma_done |=> !dma_run && !cmd_code[5]); // R11
  AST_RUN_NEEDS_CD5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_run) |-> cmd_code[5]); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= DEPTH_C); // R12
endmodule

// File: tb/cmdport_latch_tb.sv
module cmdport_latch_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_we = 1'b0;
  logic [15:0] ctl_wdata = '0;
  logic        dat_we = 1'b0;
  logic [15:0] dat_wdata = '0;
  logic [8:0]  hslot = '0;
  logic        pal_region = 1'b0;
  logic        dma_done = 1'b0;
  logic [15:0] cmd_addr, wr_addr, wr_data;
  logic [5:0]  cmd_code, dma_code, wr_code;
  logic        cmd_pending, rd_flush, reg_we, dma_run, wr_valid;
  logic [4:0]  reg_idx;
  logic [7:0]  reg_val;
  logic [2:0]  status;

  int checks = 0;
  int fails  = 0;
  logic s_flush, s_regwe;
  logic [4:0] s_idx;
  logic [7:0] s_val;

  always #4 clk = ~clk;

  cmdport_latch u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .dat_we(dat_we), .dat_wdata(dat_wdata), .hslot(hslot), .pal_region(pal_region),
    .dma_done(dma_done), .cmd_addr(cmd_addr), .cmd_code(cmd_code),
    .cmd_pending(cmd_pending), .rd_flush(rd_flush), .reg_we(reg_we),
    .reg_idx(reg_idx), .reg_val(reg_val), .dma_run(dma_run), .dma_code(dma_code),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_code(wr_code),
    .status(status)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ctl(input logic [15:0] w);
    @(negedge clk);
    ctl_we = 1'b1; ctl_wdata = w;
    #1;
    s_flush = rd_flush; s_regwe = reg_we; s_idx = reg_idx; s_val = reg_val;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic done_pulse();
    @(negedge clk); dma_done = 1'b1;
    @(negedge clk); dma_done = 1'b0;
  endtask

  task automatic data_latency(input logic [15:0] d, input int exp_lat, input string req,
                              input logic [5:0] exp_code);
    int k;
    @(negedge clk); dat_we = 1'b1; dat_wdata = d;
    @(negedge clk); dat_we = 1'b0;
    k = 1;
    while (!wr_valid && k < 200) begin
      @(negedge clk); k++;
    end
    chk(req, k, exp_lat);
    chk(req, wr_data, d);
    chk(req, wr_code, exp_code);
  endtask

  task automatic t_reset();
    chk("R1 reset addr", cmd_addr, 0);
    chk("R1 reset pend", cmd_pending, 0);
    chk("R5 reset run", dma_run, 0);
    chk("R9 reset status", status, 3'b100);
  endtask

  task automatic t_regwrite();
    ctl(16'h8110);
    chk("R8 reg_we", s_regwe, 1);
    chk("R8 reg_idx", s_idx, 1);
    chk("R8 reg_val", s_val, 8'h10);
    chk("R8 no pend", cmd_pending, 0);
    chk("R8 addr kept", cmd_addr, 0);
  endtask

  task automatic t_two_words();
    ctl(16'h4ABC);
    chk("R1 addr low", cmd_addr, 16'h0ABC);
    chk("R1 pend", cmd_pending, 1);
    chk("R1 code low", cmd_code, 6'h01);
    ctl(16'h0052);
    chk("R2 flush", s_flush, 1);
    chk("R2 addr high", cmd_addr, 16'h8ABC);
    chk("R2 pend clr", cmd_pending, 0);
    chk("R3 code", cmd_code, 6'h15);
    chk("R5 no run", dma_run, 0);
    ctl(16'h8C00);
    chk("R8 mask code", cmd_code, 6'h14);
    chk("R8 addr kept", cmd_addr, 16'h8ABC);
  endtask

  task automatic t_dma_disabled();
    ctl(16'h8100);
    ctl(16'h4000);
    ctl(16'h0080);
    chk("R4 cd5 kept", cmd_code, 6'h01);
    chk("R4 no run", dma_run, 0);
    chk("R4 status busy", status[1], 0);
  endtask

  task automatic t_immediate();
    ctl(16'h8110);
    ctl(16'h9700);
    ctl(16'h4000);
    ctl(16'h0080);
    chk("R5 run", dma_run, 1);
    chk("R5 dma_code", dma_code, 6'h21);
    chk("R9 busy", status[1], 1);
    ctl(16'h4123);
    chk("R7 addr", cmd_addr, 16'h0000);
    chk("R7 pend", cmd_pending, 0);
    ctl(16'h8C01);
    chk("R7 no reg", s_regwe, 0);
    done_pulse();
    chk("R11 run clr", dma_run, 0);
    chk("R11 cd5 clr", cmd_code, 6'h01);
  endtask

  task automatic t_fill();
    ctl(16'h9780);
    ctl(16'h8C01);
    ctl(16'h4000);
    ctl(16'h0080);
    chk("R6 deferred", dma_run, 0);
    chk("R9 busy follows code", status[1], 1);
    data_latency(16'h1234, 48, "R10 wide", 6'h21);
    chk("R6 not yet", dma_run, 0);
    @(negedge clk);
    chk("R6 run after drain", dma_run, 1);
    chk("R6 dma_code", dma_code, 6'h21);
    done_pulse();
    chk("R11 run clr", dma_run, 0);
  endtask

  task automatic t_narrow();
    ctl(16'h8C00);
    data_latency(16'hBEEF, 60, "R10 narrow", 6'h00);
    @(negedge clk);
    chk("R6 no start cd5 clear", dma_run, 0);
  endtask

  task automatic t_full();
    int n;
    @(negedge clk);
    dat_we = 1'b1;
    for (int i = 0; i < 5; i++) begin
      dat_wdata = 16'(i);
      @(negedge clk);
    end
    dat_we = 1'b0;
    n = 0;
    for (int i = 0; i < 90; i++) begin
      if (wr_valid) n++;
      @(negedge clk);
    end
    chk("R12 dropped", n, 4);
  endtask

  task automatic t_status();
    ctl(16'h8C00);
    hslot = 9'd50;  #1; chk("R9 narrow active", status[2], 0);
    hslot = 9'd134; #1; chk("R9 narrow blank", status[2], 1);
    ctl(16'h8C01);
    hslot = 9'd166; #1; chk("R9 wide active", status[2], 0);
    hslot = 9'd167; #1; chk("R9 wide blank", status[2], 1);
    hslot = 9'd10;  #1; chk("R9 wide low blank", status[2], 1);
    pal_region = 1'b1; #1; chk("R9 region", status[0], 1);
  endtask

  initial begin
    #(8 * 20000);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regwrite();
    t_two_words();
    t_dma_disabled();
    t_immediate();
    t_fill();
    t_narrow();
    t_full();
    t_status();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule